// File: doc/BRIEF.md
# Ethernet Receive Frame Checker

This block watches the byte stream of an Ethernet receiver once the preamble and start delimiter have been removed. Each frame arrives as a run of valid bytes, with the first byte flagged as start and the last byte flagged as end. While the bytes pass through, the block runs the CRC-32 frame check sequence, counts the bytes and captures the type/length field. When the end byte arrives, it decides whether the frame is good or bad.

Bytes are passed on to a downstream buffer interface. Three configuration bits shape the result. The first drops the trailing four FCS bytes and shortens the reported length to match. The second lets a frame with a bad CRC through as good, while its error statistic still counts it. The third checks the type/length field against the measured size of the frame. One cycle after the end byte, a status word appears on the outputs: a valid strobe, the good/bad flag and the length. In the same cycle, one-cycle pulses request increments of the FCS-error, short-frame and long-frame counters. Those counters live elsewhere.

Top module: `eth_rxchk`

## Requirements
- R1: The CRC is IEEE 802.3 CRC-32. It uses the reflected polynomial 0xEDB88320, starts from all ones, and takes each byte least significant bit first. A frame passes the CRC when the register left after all bytes, FCS included, equals 0xDEBB20E3 (0xC704DD7B in bit-reversed form). When the CRC fails and ignore mode is off, done_good is 0 and stat_fcs_err pulses.
- R2: The cycle after a byte with in_valid and in_eof both high, done_valid is 1 for exactly that one cycle. Every stat_* pulse happens only in a cycle where done_valid is 1.
- R3: With strip mode off, each accepted byte shows up on out_data with out_valid one cycle later, in order. For a good frame, done_len equals the number of bytes received.
- R4: With cfg_strip_fcs set, the last four bytes of a frame are never forwarded. Forwarding lags the input by four bytes, and done_len is the received count minus 4.
- R5: With cfg_ignore_fcs set, a frame whose CRC fails but which has no other fault ends with done_good = 1, and stat_fcs_err still pulses.
- R6: A frame of fewer than MIN_LEN bytes (default 64) ends with done_good = 0 and stat_short = 1.
- R7: When a frame's byte count passes MAX_LEN (default 1518), forwarding stops from that byte onward. The frame then ends with done_good = 0 and stat_long = 1. The full length is reported as MAX_LEN+1 (minus 4 in strip mode).
- R8: With cfg_len_check set, bytes 13 and 14 of the frame (zero-based offsets 12 and 13) form a big-endian field F. If F < 0x0600 and (byte count − 18) < F, the frame ends with done_good = 0 and stat_fcs_err = 1.
- R9: The field check of R8 applies only to frames of MIN_LEN to MAX_LEN bytes. A field of 0x0600 or more is never checked. With cfg_len_check clear, the field has no effect.
- R10: After reset, out_valid, done_valid, done_good and all stat_* outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| cfg_strip_fcs | input | 1 | Drop the FCS bytes and shorten the reported length |
| cfg_ignore_fcs | input | 1 | Pass frames with a bad CRC as good |
| cfg_len_check | input | 1 | Enable the type/length field check |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded byte |
| done_valid | output | 1 | End-of-frame status strobe |
| done_good | output | 1 | Frame accepted |
| done_len | output | LEN_W | Reported frame length |
| stat_fcs_err | output | 1 | FCS-error counter increment |
| stat_short | output | 1 | Short-frame counter increment |
| stat_long | output | 1 | Long-frame counter increment |

## Verification
The assertions assume that every frame opens with in_sof on its first valid byte and that in_sof/in_eof never appear outside a frame. They also assume the configuration bits hold still from the first byte of a frame through its status cycle, because the forwarded-count and ignore-mode properties read the configuration in the status cycle. The stimulus changes configuration only while the input is idle between frames, and it leaves several idle cycles after each status strobe. Frames are always at least 18 bytes long, so the header field and the FCS always exist.

// File: rtl/eth_rxchk_pkg.sv
package eth_rxchk_pkg;
  localparam int          FCS_BYTES     = 4;
  localparam int          HDR_BYTES     = 14;
  localparam int          LF_HI_POS     = 12;
  localparam int          LF_LO_POS     = 13;
  localparam logic [31:0] CRC_INIT      = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
  localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB_20E3;
  localparam logic [15:0] TYPE_MIN      = 16'h0600;

  // One byte of reflected CRC-32, least significant bit first.
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/rxchk_crc.sv
module rxchk_crc
  import eth_rxchk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        step,
  input  logic        restart,
  input  logic [7:0]  data,
  output logic [31:0] crc_nx
);
  logic [31:0] crc_q;

  always_comb crc_nx = crc_byte(restart ? CRC_INIT : crc_q, data);

  always_ff @(posedge clk) begin
    if (rst)       crc_q <= CRC_INIT;
    else if (step) crc_q <= crc_nx;
  end
endmodule

// File: rtl/rxchk_len.sv
module rxchk_len
  import eth_rxchk_pkg::*;
#(
  parameter int MAX_LEN = 1518,
  parameter int LEN_W   = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             restart,
  input  logic [7:0]       data,
  output logic [LEN_W-1:0] cnt_base,
  output logic [LEN_W-1:0] cnt_nx,
  output logic             over,
  output logic [15:0]      lf_nx
);
  logic [LEN_W-1:0] cnt_q;
  logic [15:0]      lf_q;

  always_comb begin
    cnt_base = restart ? '0 : cnt_q;
    // Saturate one past the limit so the overflow stays visible.
    cnt_nx   = (cnt_base > LEN_W'(MAX_LEN)) ? cnt_base : cnt_base + 1'b1;
    over     = cnt_nx > LEN_W'(MAX_LEN);
    lf_nx[15:8] = (cnt_base == LEN_W'(LF_HI_POS)) ? data : lf_q[15:8];
    lf_nx[7:0]  = (cnt_base == LEN_W'(LF_LO_POS)) ? data : lf_q[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lf_q  <= '0;
    end else if (step) begin
      cnt_q <= cnt_nx;
      lf_q  <= lf_nx;
    end
  end
endmodule

// File: rtl/rxchk_fwd.sv
module rxchk_fwd
  import eth_rxchk_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             strip,
  input  logic             allow,
  input  logic [LEN_W-1:0] cnt_base,
  input  logic [7:0]       data,
  output logic             out_valid,
  output logic [7:0]       out_data
);
  logic [7:0] dly [FCS_BYTES];
  logic       fwd_now;
  logic [7:0] fwd_byte;

  always_ff @(posedge clk) begin
    if (step) dly[0] <= data;
  end

  for (genvar k = 1; k < FCS_BYTES; k++) begin : g_dly
    always_ff @(posedge clk) begin
      if (step) dly[k] <= dly[k-1];
    end
  end

  always_comb begin
    if (strip) begin
      fwd_now  = step && allow && (cnt_base >= LEN_W'(FCS_BYTES));
      fwd_byte = dly[FCS_BYTES-1];
    end else begin
      fwd_now  = step && allow;
      fwd_byte = data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fwd_now;
      if (fwd_now) out_data <= fwd_byte;
    end
  end
endmodule

// File: rtl/eth_rxchk.sv
module eth_rxchk
  import eth_rxchk_pkg::*;
#(
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518,
  parameter int LEN_W   = $clog2(MAX_LEN + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             cfg_strip_fcs,
  input  logic             cfg_ignore_fcs,
  input  logic             cfg_len_check,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             done_valid,
  output logic             done_good,
  output logic [LEN_W-1:0] done_len,
  output logic             stat_fcs_err,
  output logic             stat_short,
  output logic             stat_long
);
  localparam int OVERHEAD = HDR_BYTES + FCS_BYTES;

  logic             restart, last;
  logic [31:0]      crc_nx;
  logic [LEN_W-1:0] cnt_base, cnt_nx, len_c;
  logic             over;
  logic [15:0]      lf_nx;
  logic             short_c, crc_ok, lf_bad, good_c;

  assign restart = in_valid && in_sof;
  assign last    = in_valid && in_eof;

  rxchk_crc u_crc (
    .clk(clk), .rst(rst), .step(in_valid), .restart(restart),
    .data(in_data), .crc_nx(crc_nx)
  );

  rxchk_len #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_len (
    .clk(clk), .rst(rst), .step(in_valid), .restart(restart), .data(in_data),
    .cnt_base(cnt_base), .cnt_nx(cnt_nx), .over(over), .lf_nx(lf_nx)
  );

  rxchk_fwd #(.LEN_W(LEN_W)) u_fwd (
    .clk(clk), .rst(rst), .step(in_valid), .strip(cfg_strip_fcs), .allow(!over),
    .cnt_base(cnt_base), .data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  always_comb begin
    short_c = cnt_nx < LEN_W'(MIN_LEN);
    crc_ok  = crc_nx == CRC_RESIDUE;
    lf_bad  = cfg_len_check && !short_c && !over && (lf_nx < TYPE_MIN) &&
              ((32'(cnt_nx) - 32'(OVERHEAD)) < 32'(lf_nx));
    good_c  = !short_c && !over && !lf_bad && (crc_ok || cfg_ignore_fcs);
    if (!cfg_strip_fcs)                    len_c = cnt_nx;
    else if (cnt_nx < LEN_W'(FCS_BYTES))   len_c = '0;
    else                                   len_c = cnt_nx - LEN_W'(FCS_BYTES);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_valid   <= 1'b0;
      done_good    <= 1'b0;
      done_len     <= '0;
      stat_fcs_err <= 1'b0;
      stat_short   <= 1'b0;
      stat_long    <= 1'b0;
    end else begin
      done_valid   <= last;
      done_good    <= last && good_c;
      if (last) done_len <= len_c;
      stat_fcs_err <= last && (!crc_ok || lf_bad);
      stat_short   <= last && short_c;
      stat_long    <= last && over;
    end
  end
endmodule

// File: rtl/eth_rxchk_sva.sv
module eth_rxchk_sva #(
  parameter int MAX_LEN = 1518,
  parameter int LEN_W   = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_eof,
  input logic             cfg_ignore_fcs,
  input logic             out_valid,
  input logic             done_valid,
  input logic             done_good,
  input logic [LEN_W-1:0] done_len,
  input logic             stat_fcs_err,
  input logic             stat_short,
  input logic             stat_long
);
  logic [LEN_W-1:0] fwd_q;

  always_ff @(posedge clk) begin
    if (rst || done_valid) fwd_q <= '0;
    else if (out_valid)    fwd_q <= fwd_q + 1'b1;
  end

  p_status_after_eof_r2: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> $past(in_valid && in_eof));

  p_stats_in_status_r2: assert property (@(posedge clk) disable iff (rst)
    (stat_fcs_err || stat_short || stat_long) |-> done_valid);

  p_clean_is_good_r1: assert property (@(posedge clk) disable iff (rst)
    (done_valid && !stat_fcs_err && !stat_short && !stat_long) |-> done_good);

  p_fwd_count_r3: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_good) |-> ((fwd_q + LEN_W'(out_valid)) == done_len));

  p_strict_fcs_r5: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_good && !cfg_ignore_fcs) |-> !stat_fcs_err);

  p_short_bad_r6: assert property (@(posedge clk) disable iff (rst)
    stat_short |-> (done_valid && !done_good));

  p_long_bad_r7: assert property (@(posedge clk) disable iff (rst)
    stat_long |-> (done_valid && !done_good));

  p_fwd_cap_r7: assert property (@(posedge clk) disable iff (rst)
    fwd_q <= LEN_W'(MAX_LEN));
endmodule

bind eth_rxchk eth_rxchk_sva #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_sva (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_eof(in_eof),
  .cfg_ignore_fcs(cfg_ignore_fcs), .out_valid(out_valid),
  .done_valid(done_valid), .done_good(done_good), .done_len(done_len),
  .stat_fcs_err(stat_fcs_err), .stat_short(stat_short), .stat_long(stat_long)
);

// File: tb/test_eth_rxchk.sv
module test_eth_rxchk;
  localparam int MINL = 64;
  localparam int MAXL = 128;
  localparam int LW   = $clog2(MAXL + 2);
  localparam int BUFN = 160;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0]    in_data = 0;
  logic          cfg_strip_fcs = 0, cfg_ignore_fcs = 0, cfg_len_check = 0;
  logic          out_valid, done_valid, done_good, stat_fcs_err, stat_short, stat_long;
  logic [7:0]    out_data;
  logic [LW-1:0] done_len;

  eth_rxchk #(.MIN_LEN(MINL), .MAX_LEN(MAXL)) i_eth_rxchk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .cfg_strip_fcs(cfg_strip_fcs),
    .cfg_ignore_fcs(cfg_ignore_fcs), .cfg_len_check(cfg_len_check),
    .out_valid(out_valid), .out_data(out_data), .done_valid(done_valid),
    .done_good(done_good), .done_len(done_len), .stat_fcs_err(stat_fcs_err),
    .stat_short(stat_short), .stat_long(stat_long)
  );

  logic [7:0] frm [BUFN];
  logic [7:0] rxb [BUFN];
  int rxn, ndone, nchk, nfail;
  logic g_good, g_fcs, g_short, g_long;
  int g_len;
  bit finished = 0;

  always @(negedge clk) begin
    if (out_valid) begin
      if (rxn < BUFN) rxb[rxn] = out_data;
      rxn++;
    end
    if (done_valid) begin
      ndone++;
      g_good = done_good; g_len = int'(done_len);
      g_fcs = stat_fcs_err; g_short = stat_short; g_long = stat_long;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Frame builder: reflected CRC-32 over the data, complement sent LSB byte first.
  task automatic build(input int n, input logic [15:0] lf, input bit bad);
    logic [31:0] c;
    for (int i = 0; i < n; i++) frm[i] = 8'((i * 13 + n * 5 + 3) & 255);
    frm[12] = lf[15:8];
    frm[13] = lf[7:0];
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n - 4; i++) begin
      c = c ^ {24'h0, frm[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    c = ~c;
    for (int k = 0; k < 4; k++) frm[n - 4 + k] = c[8*k +: 8];
    if (bad) frm[6] = frm[6] ^ 8'h10;
  endtask

  task automatic run(input string tag, input int n, input bit strip, input bit ign,
                     input bit lchk, input bit bad, input logic [15:0] lf);
    bit sh, lg, lb, good, dm;
    int full, elen, efwd;
    build(n, lf, bad);
    @(negedge clk);
    cfg_strip_fcs = strip; cfg_ignore_fcs = ign; cfg_len_check = lchk;
    rxn = 0; ndone = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = frm[i]; in_sof = (i == 0); in_eof = (i == n - 1);
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
    repeat (3) @(negedge clk);
    sh = n < MINL;
    lg = n > MAXL;
    lb = lchk && !sh && !lg && (lf < 16'h0600) && ((n - 18) < int'(lf));
    good = !sh && !lg && !lb && (!bad || ign);
    full = lg ? MAXL + 1 : n;
    elen = strip ? full - 4 : full;
    efwd = strip ? (lg ? MAXL - 4 : n - 4) : (lg ? MAXL : n);
    chk(ndone == 1, {"R2 status strobe count ", tag}, ndone, 1);
    chk(g_good == good, {"R1/R5/R8 done_good ", tag}, int'(g_good), int'(good));
    chk(g_len == elen, {strip ? "R4" : "R3", " done_len ", tag}, g_len, elen);
    chk(g_fcs == (bad || lb), {"R1/R5/R8 stat_fcs_err ", tag}, int'(g_fcs), int'(bad || lb));
    chk(g_short == sh, {"R6 stat_short ", tag}, int'(g_short), int'(sh));
    chk(g_long == lg, {"R7 stat_long ", tag}, int'(g_long), int'(lg));
    chk(rxn == efwd, {strip ? "R4" : "R3", " forwarded count ", tag}, rxn, efwd);
    dm = 1;
    for (int i = 0; i < efwd && i < BUFN; i++) if (rxb[i] !== frm[i]) dm = 0;
    chk(dm, {"R3 forwarded data ", tag}, int'(dm), 1);
  endtask

  initial begin
    nchk = 0; nfail = 0; rxn = 0; ndone = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(!out_valid && !done_valid && !done_good, "R10 reset outputs", int'(out_valid | done_valid | done_good), 0);
    chk(!stat_fcs_err && !stat_short && !stat_long, "R10 reset stats", int'(stat_fcs_err | stat_short | stat_long), 0);
    rst = 0;
    repeat (2) @(negedge clk);

    // Sweep: lengths around both limits, strip on/off, CRC good/bad (R1 R3 R4 R5 R6 R7)
    for (int n = MINL - 4; n <= MAXL + 4; n++)
      for (int s = 0; s < 2; s++)
        for (int b = 0; b < 2; b++)
          run("sweep", n, s[0], (n % 3) == 0, 1'b1, b[0], 16'h0800);

    // R5: ignore mode with a bad CRC passes as good
    run("R5 ignore bad crc", 100, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0800);
    // R8: field equal to payload passes, one larger fails
    run("R8 field ok", 100, 1'b0, 1'b0, 1'b1, 1'b0, 16'd82);
    run("R8 field over", 100, 1'b0, 1'b0, 1'b1, 1'b0, 16'd83);
    run("R8 field 0x05FF", 100, 1'b1, 1'b0, 1'b1, 1'b0, 16'h05FF);
    run("R8 lower bound", MINL, 1'b0, 1'b0, 1'b1, 1'b0, 16'd47);
    run("R8 upper bound", MAXL, 1'b0, 1'b0, 1'b1, 1'b0, 16'd111);
    // R9: type values, disabled check and out-of-range sizes
    run("R9 type 0x0600", 100, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0600);
    run("R9 check off", 100, 1'b0, 1'b0, 1'b0, 1'b0, 16'd83);
    run("R9 short frame", 50, 1'b0, 1'b0, 1'b1, 1'b0, 16'd200);
    run("R9 long frame", MAXL + 2, 1'b0, 1'b0, 1'b1, 1'b0, 16'd200);

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule